// File: doc/BRIEF.md
# Instruction Fetch Front End with Direct-Mapped Word Cache

This block sits between an instruction fetch stage and a physical memory read port. It takes one fetch address at a time, together with a flag that says whether 16-bit compressed encodings are enabled. It returns a single instruction, which may be 16 or 32 bits long. Word-aligned fetches are looked up in a direct-mapped cache of 32-bit words, and a miss refills the cache. Fetches that start at a halfword offset are built from one or two memory reads and never touch the cache. A flush input invalidates the whole cache in one cycle.

Both streaming edges use valid/ready handshakes. A fetch transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so it stays low from that transfer until the response has been taken. The response holds `rsp_valid` and all response fields steady until a cycle with `rsp_ready` high. The memory request holds `mem_req_valid` and its address steady until `mem_req_ready` is high. The memory read return has no ready: only one memory request is ever outstanding, so the block always takes the return.

Top module: `ifetch_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A new fetch is accepted only while the block is idle. `req_ready` stays 0 from acceptance until the response is taken. While `rsp_ready` is 0, `rsp_valid`, `rsp_insn`, `rsp_wide` and `rsp_fault` hold their values.
- R3: An aligned fetch (address mod 4 = 0) that misses issues exactly one memory read of the word at that address. It returns that word in `rsp_insn` and stores it at entry (address/4) mod ENTRIES.
- R4: A hit requires the stored tag to equal the full fetch address, with bit 0 acting as a valid marker. A hit responds with no memory read, and `rsp_valid` appears on the second rising edge after acceptance. An address that shares an index but differs in its upper bits misses and replaces the entry.
- R5: When `req_cmode`=1 and address mod 4 = 2, the block reads the word at address−2 and takes its bits 31:16 as the low halfword. If that halfword's bits 1:0 are not 2'b11, the response is `{16'h0, low}` with `rsp_wide`=0, after exactly one memory read.
- R6: If that low halfword's bits 1:0 are 2'b11, a second read of the word at address+2 follows. The response is `{word2[15:0], low}` with `rsp_wide`=1, after exactly two memory reads.
- R7: Halfword-offset fetches never write the cache. An entry filled before such a fetch still hits afterwards.
- R8: A fetch with address bits 1:0 nonzero that is not the halfword case of R5 responds with `rsp_fault`=1, `rsp_insn`=0 and `rsp_wide`=0, and makes no memory read.
- R9: A one-cycle `flush` clears every valid marker. A fetch whose lookup cycle coincides with `flush` is treated as a miss. A refill racing a flush is dropped.
- R10: For aligned fetches, `rsp_wide` = 1 when `req_cmode`=0 or `rsp_insn[1:0]`=2'b11, and 0 otherwise.
- R11: Memory request addresses are always word aligned. A request holds its address until `mem_req_ready` is seen, and at most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cache entries |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Block idle, fetch can be taken |
| req_addr | input | ADDR_W | Fetch address |
| req_cmode | input | 1 | Compressed encodings enabled |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_insn | output | 32 | Returned instruction |
| rsp_wide | output | 1 | 1 = 32-bit instruction, 0 = 16-bit |
| rsp_fault | output | 1 | Misaligned fetch fault |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Word-aligned read address |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 32 | Read data word |

## Verification
A corrupted tag or valid marker shows up at the memory port on the very next fetch to that index: a read appears where none was due, or is missing where one was due. A wrong tag match also returns a wrong word, so the bench counts memory reads for every fetch and checks every returned word. Because the bench model of memory is a known arithmetic function of the word address, a wrong halfword selection or a missed second read changes `rsp_insn` or `rsp_wide` in the response to that same fetch. A stale hit after a flush costs one missing memory read, which the per-fetch read count catches at once.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } fsm_t;

  // A 16-bit parcel starts a 32-bit instruction when both low bits are set.
  function automatic logic starts_wide(input logic [1:0] lsb);
    return lsb == 2'b11;
  endfunction
endpackage

// File: rtl/ifc_store.sv
module ifc_store #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:1] rd_tag,
  output logic              rd_hit,
  output logic [31:0]       rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:1] wr_tag,
  input  logic [31:0]       wr_data
);
  logic [ADDR_W-1:1] tag_hi [ENTRIES];
  logic [31:0]       words  [ENTRIES];
  logic [ENTRIES-1:0] vld;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  assign rd_idx = rd_tag[IDX_W+1:2];
  assign wr_idx = wr_tag[IDX_W+1:2];

  // Bit 0 of each stored tag: the valid marker, one flop per entry.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_vld
    always_ff @(posedge clk) begin
      if (!rst_n)                                      vld[e] <= 1'b0;
      else if (flush)                                  vld[e] <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(e))           vld[e] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_hi[wr_idx] <= wr_tag;
      words[wr_idx]  <= wr_data;
    end
  end

  assign rd_hit  = vld[rd_idx] && (tag_hi[rd_idx] == rd_tag);
  assign rd_data = words[rd_idx];

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));

  p_fill_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> vld[$past(wr_idx)]);
endmodule

// File: rtl/ifc_merge.sv
module ifc_merge (
  input  logic        half,
  input  logic        phase2,
  input  logic        cmode,
  input  logic [15:0] lo_part,
  input  logic [31:0] word,
  output logic [31:0] out_insn,
  output logic        out_wide,
  output logic        need_hi
);
  import ifc_pkg::*;

  always_comb begin
    out_insn = word;
    out_wide = 1'b1;
    need_hi  = 1'b0;
    if (!half) begin
      out_wide = !cmode || starts_wide(word[1:0]);
    end else if (!phase2) begin
      out_insn = {16'h0000, word[31:16]};
      out_wide = 1'b0;
      need_hi  = starts_wide(word[17:16]);
    end else begin
      out_insn = {word[15:0], lo_part};
      out_wide = 1'b1;
    end
  end
endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cmode,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_insn,
  output logic              rsp_wide,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic [ADDR_W-1:1] st_tag,
  input  logic              st_hit,
  input  logic [31:0]       st_rdata,
  output logic              st_wr_en,
  output logic [31:0]       st_wdata
);
  import ifc_pkg::*;

  fsm_t              state;
  logic [ADDR_W-1:0] addr_q;
  logic              cmode_q, half_q, phase2_q, wide_q, fault_q;
  logic [15:0]       lo_q;
  logic [31:0]       insn_q;

  logic [31:0] mg_word, mg_insn;
  logic        mg_wide, mg_need_hi;

  assign mg_word = (state == ST_LOOK) ? st_rdata : mem_rsp_data;

  ifc_merge u_merge (
    .half     (half_q),
    .phase2   (phase2_q),
    .cmode    (cmode_q),
    .lo_part  (lo_q),
    .word     (mg_word),
    .out_insn (mg_insn),
    .out_wide (mg_wide),
    .need_hi  (mg_need_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      cmode_q  <= 1'b0;
      half_q   <= 1'b0;
      phase2_q <= 1'b0;
      wide_q   <= 1'b0;
      fault_q  <= 1'b0;
      lo_q     <= '0;
      insn_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q   <= req_addr;
          cmode_q  <= req_cmode;
          half_q   <= req_cmode && (req_addr[1:0] == 2'b10);
          phase2_q <= 1'b0;
          fault_q  <= 1'b0;
          state    <= ST_LOOK;
        end
        ST_LOOK: begin
          if (half_q) begin
            state <= ST_MREQ;
          end else if (addr_q[1:0] != 2'b00) begin
            fault_q <= 1'b1;
            insn_q  <= '0;
            wide_q  <= 1'b0;
            state   <= ST_RESP;
          end else if (st_hit && !flush) begin
            insn_q <= mg_insn;
            wide_q <= mg_wide;
            state  <= ST_RESP;
          end else begin
            state <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) state <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          if (mg_need_hi) begin
            lo_q     <= mem_rsp_data[31:16];
            phase2_q <= 1'b1;
            state    <= ST_MREQ;
          end else begin
            insn_q <= mg_insn;
            wide_q <= mg_wide;
            state  <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_insn      = insn_q;
  assign rsp_wide      = wide_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = (state == ST_MREQ);
  assign mem_req_addr  = {addr_q[ADDR_W-1:2], 2'b00} + (phase2_q ? ADDR_W'(4) : ADDR_W'(0));
  assign st_tag        = addr_q[ADDR_W-1:1];
  assign st_wr_en      = (state == ST_MWAIT) && mem_rsp_valid && !half_q;
  assign st_wdata      = mem_rsp_data;

  p_idle_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req_valid));

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_insn) && $stable(rsp_wide)
                                   && $stable(rsp_fault)));

  p_mreq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_mreq_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  p_short_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_wide && !rsp_fault) |-> (rsp_insn[1:0] != 2'b11));

  p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_insn == '0 && !rsp_wide));
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cmode,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_insn,
  output logic              rsp_wide,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ADDR_W-1:1] st_tag;
  logic              st_hit, st_wr_en;
  logic [31:0]       st_rdata, st_wdata;

  ifc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_cmode     (req_cmode),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_insn      (rsp_insn),
    .rsp_wide      (rsp_wide),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .st_tag        (st_tag),
    .st_hit        (st_hit),
    .st_rdata      (st_rdata),
    .st_wr_en      (st_wr_en),
    .st_wdata      (st_wdata)
  );

  ifc_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .rd_tag  (st_tag),
    .rd_hit  (st_hit),
    .rd_data (st_rdata),
    .wr_en   (st_wr_en),
    .wr_tag  (st_tag),
    .wr_data (st_wdata)
  );
endmodule

// File: tb/sim_ifetch_cache.sv
`timescale 1ns/1ps
module sim_ifetch_cache;
  localparam int AW = 16;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_cmode = 1'b0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [31:0]   rsp_insn;
  logic          rsp_wide, rsp_fault;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [31:0]   mem_rsp_data;

  always #5 clk = ~clk;

  ifetch_cache #(.ADDR_W(AW), .ENTRIES(NE)) u0 (.*);

  int checks = 0, fails = 0, mem_reqs = 0, align_bad = 0, pend = 0, rr = 0;
  int busy_bad = 0, hold_bad = 0;
  bit done = 1'b0;
  logic [AW-1:0] pend_addr;
  logic [AW-1:0] req_log [4];

  function automatic logic [31:0] mword(input logic [AW-1:0] a);
    logic [15:0] w;
    w = {2'b00, a[AW-1:2]};
    return {w * 16'd37 + 16'd3, w * 16'd11 + 16'd2};
  endfunction

  // memory model: stalls ready on a pattern, answers two cycles after a request
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      pend <= 0;
      rr <= 0;
    end else begin
      rr <= rr + 1;
      mem_req_ready <= (rr % 3) != 1;
      mem_rsp_valid <= 1'b0;
      if (pend == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mword(pend_addr);
      end
      if (pend != 0) pend <= pend - 1;
      if (mem_req_valid && mem_req_ready) begin
        if (pend != 0 || mem_req_addr[1:0] != 2'b00) align_bad <= align_bad + 1;
        pend <= 2;
        pend_addr <= mem_req_addr;
        req_log[mem_reqs % 4] <= mem_req_addr;
        mem_reqs <= mem_reqs + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic fetch(input logic [AW-1:0] a, input logic cm, input int hold,
                       input bit flush_look, output logic [31:0] ins, output logic wd,
                       output logic flt, output int nreq, output int lat, output int r0);
    logic [31:0] first;
    @(negedge clk);
    req_addr = a; req_cmode = cm; req_valid = 1'b1; r0 = mem_reqs;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; lat = 1;
    if (flush_look) flush = 1'b1;
    while (!rsp_valid) begin
      if (req_ready) busy_bad++;
      @(negedge clk);
      flush = 1'b0;
      lat++;
    end
    flush = 1'b0;
    first = rsp_insn;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_insn != first || req_ready) hold_bad++;
    end
    ins = rsp_insn; wd = rsp_wide; flt = rsp_fault; nreq = mem_reqs - r0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic aligned(input int w, input logic cm, input int exp_req, input string rq);
    logic [31:0] ins, ew;
    logic wd, flt;
    int n, lat, r0;
    fetch(AW'(w * 4), cm, 0, 1'b0, ins, wd, flt, n, lat, r0);
    ew = mword(AW'(w * 4));
    chk(ins == ew && !flt, rq, "aligned word", ins, ew);
    chk(wd == (!cm || ew[1:0] == 2'b11), "R10", "wide flag", {31'd0, wd}, {31'd0, (!cm || ew[1:0] == 2'b11)});
    chk(n == exp_req, rq, "memory reads", n, exp_req);
    if (exp_req == 1) chk(req_log[r0 % 4] == AW'(w * 4), "R3", "read address", {16'd0, req_log[r0 % 4]}, w * 4);
    if (exp_req == 0) chk(lat == 2, "R4", "hit latency", lat, 2);
  endtask

  initial begin
    logic [31:0] ins, ew, w1, w2;
    logic wd, flt;
    int n, lat, r0;
    logic [15:0] lo;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "reset state",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

    // R3/R4/R10: miss then immediate hit over two aliasing sets of indices
    for (int w = 0; w < 2 * NE; w++) begin
      aligned(w, w[0], 1, "R3");
      aligned(w, w[0], 0, "R4");
    end
    // upper set now resident: hits; lower set aliased out: misses and refills
    for (int w = NE; w < 2 * NE; w++) aligned(w, 1'b0, 0, "R4");
    for (int w = 0; w < NE; w++) aligned(w, 1'b1, 1, "R4");

    // R5/R6: every halfword offset, with one or two reads depending on the low parcel
    for (int w = 0; w < 2 * NE; w++) begin
      fetch(AW'(w * 4 + 2), 1'b1, 0, 1'b0, ins, wd, flt, n, lat, r0);
      w1 = mword(AW'(w * 4));
      w2 = mword(AW'(w * 4 + 4));
      lo = w1[31:16];
      if (lo[1:0] != 2'b11) begin
        chk(ins == {16'h0, lo} && !wd && !flt, "R5", "short parcel", ins, {16'h0, lo});
        chk(n == 1, "R5", "memory reads", n, 1);
        chk(req_log[r0 % 4] == AW'(w * 4), "R5", "read address", {16'd0, req_log[r0 % 4]}, w * 4);
      end else begin
        chk(ins == {w2[15:0], lo} && wd && !flt, "R6", "joined parcels", ins, {w2[15:0], lo});
        chk(n == 2, "R6", "memory reads", n, 2);
        chk(req_log[(r0 + 1) % 4] == AW'(w * 4 + 4), "R6", "second address",
            {16'd0, req_log[(r0 + 1) % 4]}, w * 4 + 4);
      end
    end

    // R7: halfword fetches left the lower set resident
    for (int w = 0; w < NE; w++) aligned(w, 1'b0, 0, "R7");

    // R8: misaligned fetches fault without reading memory
    for (int o = 1; o < 4; o++) begin
      for (int c = 0; c < 2; c++) begin
        if (!(o == 2 && c == 1)) begin
          fetch(AW'(32 + o), c[0], 0, 1'b0, ins, wd, flt, n, lat, r0);
          chk(flt && ins == 0 && !wd, "R8", "fault response", {ins[30:0], flt}, 32'h1);
          chk(n == 0, "R8", "no memory read", n, 0);
        end
      end
    end

    // R9: flush while idle, then flush during the lookup cycle
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    aligned(3, 1'b0, 1, "R9");
    aligned(5, 1'b0, 1, "R9");
    fetch(AW'(3 * 4), 1'b0, 0, 1'b1, ins, wd, flt, n, lat, r0);
    ew = mword(AW'(12));
    chk(n == 1, "R9", "flush at lookup misses", n, 1);
    chk(ins == ew, "R9", "word after flush", ins, ew);
    aligned(3, 1'b0, 0, "R9");
    aligned(5, 1'b0, 1, "R9");

    // R2: held response and busy ready
    fetch(AW'(6 * 4), 1'b0, 3, 1'b0, ins, wd, flt, n, lat, r0);
    fetch(AW'(9 * 4 + 2), 1'b1, 4, 1'b0, ins, wd, flt, n, lat, r0);
    chk(hold_bad == 0, "R2", "response held under back-pressure", hold_bad, 0);
    chk(busy_bad == 0, "R2", "ready low while busy", busy_bad, 0);
    chk(align_bad == 0, "R11", "aligned single outstanding read", align_bad, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule